// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Block

A 32-bit general-purpose I/O register block on a simple byte-addressed register bus. It holds a pin-level register, a direction register (a 1 marks a bit as an output) and a free scratch register. Software does not write the level register directly. It uses a set port and a clear port. Each of these ports applies its whole written mask, but only when that mask shares at least one bit with the output bits of the direction register. A mask with no such overlap is dropped and raises a one-cycle reject pulse. Three offsets, meant for later edge-detect configuration, accept writes and keep nothing. Nine interrupt lines exist at the edge of the block: bits 7..0 form the low group and bit 8 is the high line. All nine are held low.

The bus uses plain strobes and never applies back-pressure. A write strobe is accepted in the cycle it is high. A read strobe is accepted in its cycle, and its data comes back with a one-cycle `rd_valid` pulse in the next cycle. No ready signal exists on either side, so the requester must capture the read data on that pulse. Only aligned full-word accesses are decoded. A read in the same cycle as a write returns the value from before the write.

Top module: `gpio_regblock`

## Requirements
- R1: After reset the level, direction and scratch registers read zero, and `rd_valid`, `wr_reject` and `rdata` are low.
- R2: A read strobe in cycle n gives `rd_valid` high and the read data on `rdata` in cycle n+1, for exactly one cycle per strobe.
- R3: The direction register at byte offset 0x04 stores any 32-bit word written to it and reads it back unchanged.
- R4: A write to offset 0x08 whose value shares at least one set bit with the direction register ORs the entire value into the level register, including bits configured as inputs.
- R5: A write to offset 0x0C under the same overlap condition clears every bit of the level register that is set in the value, including input bits.
- R6: A set or clear write whose value has no bit in common with the direction register, a zero value included, leaves the level register unchanged and drives `wr_reject` high for exactly the next cycle.
- R7: Writes to offset 0x00, to offsets 0x10, 0x14 and 0x18, and to any unmapped offset change no register.
- R8: Reads of any offset other than 0x00 (level), 0x04 (direction) and 0x20 (scratch) return zero. This covers 0x08, 0x0C, 0x10, 0x14 and 0x18.
- R9: The scratch register at offset 0x20 stores any 32-bit word and reads it back.
- R10: All nine interrupt outputs stay low at all times.
- R11: An access whose address has nonzero bits 1..0 is unmapped. Its write changes nothing and its read returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one access per high cycle |
| rd_en | input | 1 | Read strobe, one access per high cycle |
| addr | input | ADDR_W (8) | Byte address of the access |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, valid while rd_valid is high |
| rd_valid | output | 1 | One-cycle pulse marking read data |
| wr_reject | output | 1 | One-cycle pulse after a dropped set/clear write |
| irq | output | NUM_IRQ (9) | Interrupt lines, low group in bits 7..0, high line in bit 8, always low |

## Verification
Assertions check several rules on every cycle. The read-valid pulse follows each strobe by one cycle. An accepted set or clear updates the level register with the whole mask. A gated write leaves the level stable and raises the reject flag. The level and configuration registers hold when not addressed, and unmapped reads return zero. Only the bench's scenarios can show the full address map seen from the ports. It sweeps every word offset and a set of misaligned addresses for reads and writes, and runs a long sequence of mixed set and clear masks against an arithmetic model. That sequence covers the case where the mask reaches into input bits, plus the reset values and the constant interrupt lines.

// File: rtl/gpio_rb_pkg.sv
package gpio_rb_pkg;
  localparam int OFS_LEVEL = 'h00;
  localparam int OFS_DIR   = 'h04;
  localparam int OFS_SET   = 'h08;
  localparam int OFS_CLR   = 'h0C;
  localparam int OFS_RISE  = 'h10;
  localparam int OFS_FALL  = 'h14;
  localparam int OFS_EVT   = 'h18;
  localparam int OFS_AUX   = 'h20;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LEVEL,
    SEL_DIR,
    SEL_SET,
    SEL_CLR,
    SEL_SINK,
    SEL_AUX
  } reg_sel_e;
endpackage

// File: rtl/gpio_rb_decode.sv
module gpio_rb_decode #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]    addr,
  output gpio_rb_pkg::reg_sel_e sel
);
  import gpio_rb_pkg::*;

  always_comb begin
    sel = SEL_NONE;
    if (addr[1:0] == 2'b00) begin
      if (addr == ADDR_W'(OFS_LEVEL))      sel = SEL_LEVEL;
      else if (addr == ADDR_W'(OFS_DIR))   sel = SEL_DIR;
      else if (addr == ADDR_W'(OFS_SET))   sel = SEL_SET;
      else if (addr == ADDR_W'(OFS_CLR))   sel = SEL_CLR;
      else if (addr == ADDR_W'(OFS_RISE) ||
               addr == ADDR_W'(OFS_FALL) ||
               addr == ADDR_W'(OFS_EVT))   sel = SEL_SINK;
      else if (addr == ADDR_W'(OFS_AUX))   sel = SEL_AUX;
      else                                 sel = SEL_NONE;
    end
  end
endmodule

// File: rtl/gpio_rb_wreg.sv
module gpio_rb_wreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end

  // R7: unaddressed register keeps its value
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/gpio_rb_level.sv
module gpio_rb_level #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] dir,
  output logic [W-1:0] level,
  output logic         reject
);
  logic overlap;
  assign overlap = |(dir & wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level  <= '0;
      reject <= 1'b0;
    end else begin
      reject <= (set_we || clr_we) && !overlap;
      if (set_we && overlap)      level <= level | wdata;
      else if (clr_we && overlap) level <= level & ~wdata;
    end
  end

  p_set_whole_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && (|(dir & wdata))) |=> level == ($past(level) | $past(wdata)));

  p_clr_whole_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && (|(dir & wdata))) |=> level == ($past(level) & ~$past(wdata)));

  p_gated_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_we || clr_we) && !(|(dir & wdata))) |=> ($stable(level) && reject));

  p_reject_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_we || clr_we) |=> !reject);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(level));
endmodule

// File: rtl/gpio_rb_rdport.sv
module gpio_rb_rdport #(
  parameter int W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_en,
  input  gpio_rb_pkg::reg_sel_e sel,
  input  logic [W-1:0]          level,
  input  logic [W-1:0]          dir,
  input  logic [W-1:0]          aux,
  output logic [W-1:0]          rdata,
  output logic                  rd_valid
);
  import gpio_rb_pkg::*;

  logic [W-1:0] sel_data;

  always_comb begin
    unique case (sel)
      SEL_LEVEL: sel_data = level;
      SEL_DIR:   sel_data = dir;
      SEL_AUX:   sel_data = aux;
      default:   sel_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= sel_data;
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  p_valid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel != SEL_LEVEL && sel != SEL_DIR && sel != SEL_AUX) |=> rdata == '0);
endmodule

// File: rtl/gpio_regblock.sv
module gpio_regblock #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int NUM_IRQ = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid,
  output logic              wr_reject,
  output logic [NUM_IRQ-1:0] irq
);
  import gpio_rb_pkg::*;

  reg_sel_e          sel;
  logic [DATA_W-1:0] level_q, dir_q, aux_q;
  logic              dir_we, aux_we, set_we, clr_we;

  gpio_rb_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(addr), .sel(sel));

  assign dir_we = wr_en && (sel == SEL_DIR);
  assign aux_we = wr_en && (sel == SEL_AUX);
  assign set_we = wr_en && (sel == SEL_SET);
  assign clr_we = wr_en && (sel == SEL_CLR);

  gpio_rb_wreg #(.W(DATA_W)) u_dir (
    .clk(clk), .rst_n(rst_n), .we(dir_we), .wdata(wdata), .q(dir_q));

  gpio_rb_wreg #(.W(DATA_W)) u_aux (
    .clk(clk), .rst_n(rst_n), .we(aux_we), .wdata(wdata), .q(aux_q));

  gpio_rb_level #(.W(DATA_W)) u_lvl (
    .clk(clk), .rst_n(rst_n), .set_we(set_we), .clr_we(clr_we),
    .wdata(wdata), .dir(dir_q), .level(level_q), .reject(wr_reject));

  gpio_rb_rdport #(.W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .sel(sel),
    .level(level_q), .dir(dir_q), .aux(aux_q),
    .rdata(rdata), .rd_valid(rd_valid));

  // Interrupt generation is not part of this block; lines are parked low.
  assign irq = '0;

  // R3: a direction write lands in the next cycle
  p_dir_written_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(OFS_DIR)) |=> dir_q == $past(wdata));

  // R9: scratch write lands in the next cycle
  p_aux_written_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(OFS_AUX)) |=> aux_q == $past(wdata));

  // R11: misaligned writes touch nothing
  p_misaligned_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[1:0] != 2'b00) |=> ($stable(level_q) && $stable(dir_q) && $stable(aux_q)));
endmodule

// File: tb/tb_gpio_regblock.sv
module tb_gpio_regblock;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rd_valid;
  logic        wr_reject;
  logic [8:0]  irq;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] m_lvl = '0, m_dir = '0, m_aux = '0;
  logic [31:0] seed = 32'h1234_5678;
  logic [31:0] got;
  logic        got_v;
  logic        got_rej;

  always #(CLK_NS/2) clk = ~clk;

  gpio_regblock dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
    .wr_reject(wr_reject), .irq(irq));

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    if (a == 8'h00) return m_lvl;
    if (a == 8'h04) return m_dir;
    if (a == 8'h20) return m_aux;
    return '0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    got_rej = wr_reject;
  endtask

  task automatic do_read(input logic [7:0] a);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    got = rdata;
    got_v = rd_valid;
  endtask

  task automatic check_regs(input string tag);
    do_read(8'h00); check(got == m_lvl, tag, got, m_lvl);
    do_read(8'h04); check(got == m_dir, tag, got, m_dir);
    do_read(8'h20); check(got == m_aux, tag, got, m_aux);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic        exp_rej;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state at the ports
    check(rd_valid == 1'b0, "R1 rd_valid", 32'(rd_valid), 0);
    check(wr_reject == 1'b0, "R1 wr_reject", 32'(wr_reject), 0);
    check(rdata == '0, "R1 rdata", rdata, 0);
    check(irq == '0, "R10 irq after reset", 32'(irq), 0);
    do_read(8'h00);
    check(got == '0, "R1 level", got, 0);
    check(got_v == 1'b1, "R2 rd_valid with data", 32'(got_v), 1);
    @(negedge clk);
    check(rd_valid == 1'b0, "R2 single-cycle pulse", 32'(rd_valid), 0);
    do_read(8'h04); check(got == '0, "R1 direction", got, 0);
    do_read(8'h20); check(got == '0, "R1 scratch", got, 0);

    // R3 direction and R9 scratch read-back
    for (int k = 0; k < 8; k++) begin
      seed = nxt(seed); v = seed;
      do_write(8'h04, v); m_dir = v;
      do_read(8'h04); check(got == m_dir, "R3 direction read-back", got, m_dir);
      check(got_v == 1'b1, "R2 valid", 32'(got_v), 1);
      seed = nxt(seed); v = seed;
      do_write(8'h20, v); m_aux = v;
      do_read(8'h20); check(got == m_aux, "R9 scratch read-back", got, m_aux);
    end

    // R6 gated writes with no output bits
    do_write(8'h04, 32'h0); m_dir = '0;
    do_write(8'h08, 32'hFFFF_FFFF);
    check(got_rej == 1'b1, "R6 reject on set", 32'(got_rej), 1);
    @(negedge clk);
    check(wr_reject == 1'b0, "R6 reject is one cycle", 32'(wr_reject), 0);
    do_read(8'h00); check(got == '0, "R6 level unchanged", got, 0);

    // R4 whole mask including input bits
    do_write(8'h04, 32'h0000_0001); m_dir = 32'h1;
    do_write(8'h08, 32'h0000_F0F1); m_lvl = 32'hF0F1;
    check(got_rej == 1'b0, "R4 no reject", 32'(got_rej), 0);
    do_read(8'h00); check(got == 32'hF0F1, "R4 input bits set too", got, 32'hF0F1);

    // R5 clear with overlap, then clear without overlap
    do_write(8'h0C, 32'h0000_0001); m_lvl = 32'hF0F0;
    do_read(8'h00); check(got == 32'hF0F0, "R5 clear", got, 32'hF0F0);
    do_write(8'h0C, 32'h0000_F000);
    check(got_rej == 1'b1, "R6 reject on clear", 32'(got_rej), 1);
    do_read(8'h00); check(got == 32'hF0F0, "R6 clear dropped", got, 32'hF0F0);
    do_write(8'h04, 32'h0000_8000); m_dir = 32'h8000;
    do_write(8'h0C, 32'h0000_F000); m_lvl = 32'h00F0;
    do_read(8'h00); check(got == 32'h00F0, "R5 clear input bits too", got, 32'h00F0);
    do_write(8'h08, 32'h0);
    check(got_rej == 1'b1, "R6 zero mask rejected", 32'(got_rej), 1);

    // R4/R5/R6 mixed sweep against the model
    for (int i = 0; i < 96; i++) begin
      if (i % 6 == 0) begin
        seed = nxt(seed); v = seed;
        seed = nxt(seed); v = v & seed;
        seed = nxt(seed); v = v & seed;
        do_write(8'h04, v); m_dir = v;
      end
      seed = nxt(seed); v = seed & (i[0] ? 32'h00FF_00FF : 32'hFFFF_FFFF);
      if (i % 4 == 3) v = v & ~m_dir;
      exp_rej = ((m_dir & v) == '0);
      if (i[1]) begin
        do_write(8'h0C, v);
        if (!exp_rej) m_lvl = m_lvl & ~v;
        check(got_rej == exp_rej, "R5/R6 clear reject flag", 32'(got_rej), 32'(exp_rej));
      end else begin
        do_write(8'h08, v);
        if (!exp_rej) m_lvl = m_lvl | v;
        check(got_rej == exp_rej, "R4/R6 set reject flag", 32'(got_rej), 32'(exp_rej));
      end
      do_read(8'h00); check(got == m_lvl, "R4/R5 level model", got, m_lvl);
    end

    // R7 writes to non-storing offsets change nothing
    for (int w = 0; w < 64; w++) begin
      logic [7:0] a;
      a = 8'(w * 4);
      if (a != 8'h04 && a != 8'h08 && a != 8'h0C && a != 8'h20) begin
        seed = nxt(seed);
        do_write(a, seed);
        if (a == 8'h00 || a == 8'h10 || a == 8'h14 || a == 8'h18)
          check_regs("R7 named sink offset");
      end
    end
    check_regs("R7 after unmapped sweep");

    // R8 read map over all word offsets
    for (int w = 0; w < 64; w++) begin
      logic [7:0] a;
      a = 8'(w * 4);
      do_read(a);
      check(got == exp_rd(a), "R8 read map", got, exp_rd(a));
    end

    // R11 misaligned addresses
    for (int j = 0; j < 6; j++) begin
      logic [7:0] a;
      case (j)
        0: a = 8'h01; 1: a = 8'h02; 2: a = 8'h03;
        3: a = 8'h05; 4: a = 8'h09; default: a = 8'h21;
      endcase
      seed = nxt(seed);
      do_write(a, seed | 32'h1);
      check(got_rej == 1'b0, "R11 no reject", 32'(got_rej), 0);
      check_regs("R11 misaligned write");
      do_read(a); check(got == '0, "R11 misaligned read", got, 0);
    end

    check(irq == '0, "R10 irq at end", 32'(irq), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(negedge clk) begin
    if (rst_n && irq != '0) begin
      n_chk++; n_fail++;
      $display("FAIL R10 irq actual=%h expected=%h", 32'(irq), 32'd0);
    end
  end
endmodule